// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler and Watchdog

This block combines an 8-bit free-running event counter, a watchdog timer and a single power-of-two prescaler that serves exactly one of the two at any time. A 6-bit mode register chooses the counter's event source, which is either the instruction-cycle tick or an edge on an external timer pin. It also picks which edge of that pin counts, where the prescaler is routed and which division ratio the prescaler applies. The same 3-bit ratio code divides by twice as much when the prescaler feeds the counter as when it feeds the watchdog.

The watchdog advances on a slow basic tick, which stands in for a free-running oscillator, either directly or through the prescaler. When it overflows it emits a one-cycle reset pulse and raises a timeout flag. If the block was put to sleep beforehand, it also emits a wake pulse. A clear-watchdog command or a sleep command restarts the watchdog. Software-style writes to the counter and to the mode register take effect at the next clock edge.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset the counter reads 0 and wd_rst, wake and wd_tmo are 0. The mode register holds 6'h3F, which selects the pin as source, the falling edge, the prescaler on the watchdog and ratio code 111, so instruction ticks do not change the counter.
- R2: The mode word is laid out as follows: bits [2:0] hold the ratio code. Bit 3 routes the prescaler, 0 to the counter and 1 to the watchdog. Bit 4 selects the counted pin edge, 0 for rising and 1 for falling. Bit 5 selects the counter source, 0 for cyc_tick and 1 for the pin. Every mode write clears the prescaler.
- R3: With mode bit 3 = 1, the counter adds 1 for each source event and wraps from 8'hFF to 8'h00. With no event and no write it holds its value.
- R4: With mode bit 3 = 0, the counter adds 1 once per 2^(ratio+1) source events (2 up to 256), counted from the last prescaler clear.
- R5: With mode bit 5 = 1, the pin passes through a two-flop synchronizer. Only the selected edge counts, and the counter shows it within three clock cycles. The opposite edge and cyc_tick are ignored.
- R6: A counter write loads cnt_wdata at the next edge and takes priority over a simultaneous increment. With mode bit 3 = 0 it also clears the prescaler.
- R7: With mode bit 3 = 0, the 2^WDT_W-th wd_tick after a restart makes wd_rst high for exactly one cycle in the next cycle and sets wd_tmo.
- R8: With mode bit 3 = 1, the watchdog times out after 2^WDT_W * 2^ratio wd_ticks (ratio 1 up to 128).
- R9: wd_clr or sleep_req restarts the watchdog count and clears wd_tmo. With mode bit 3 = 1, either of them also clears the prescaler.
- R10: sleep_req puts the block to sleep. A timeout while asleep pulses wake together with wd_rst and ends the sleep. A timeout while awake leaves wake at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| tpin | input | 1 | Asynchronous external timer pin |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| wd_clr | input | 1 | Clear-watchdog command |
| sleep_req | input | 1 | Sleep entry command |
| wd_tick | input | 1 | Basic watchdog tick |
| cnt_val | output | CNT_W | Counter value |
| wd_rst | output | 1 | Watchdog reset pulse |
| wake | output | 1 | Wake pulse on timeout during sleep |
| wd_tmo | output | 1 | Timeout flag |

## Verification
The hardest state to reach is a prescaler that holds a partial count at the moment it should be cleared. Only that state tells a correct clear apart from a missing one, because an empty prescaler gives the same results either way. The bench first feeds a few events that leave the prescaler part-way through a division. It then issues the clearing action (a counter write, a mode write or a watchdog restart) and counts events up to the exact boundary. Off-by-one sampling around the watchdog overflow is avoided by ticking to one short of the overflow, confirming no pulse has occurred, and then giving the final tick.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int PS_W   = 3;
    localparam int PRE_W  = 1 << PS_W;
    localparam int MODE_W = PS_W + 3;

    typedef struct packed {
        logic            src_pin;
        logic            fall_edge;
        logic            to_wdog;
        logic [PS_W-1:0] ratio;
    } tmode_t;

    localparam tmode_t MODE_RST = tmode_t'({MODE_W{1'b1}});

    // low-bit mask whose all-ones state marks the prescaler terminal count
    function automatic logic [PRE_W-1:0] ratio_mask(input logic [PS_W-1:0] r,
                                                    input logic to_wdog);
        logic [PRE_W-1:0] one;
        int sh;
        one = {{(PRE_W-1){1'b0}}, 1'b1};
        sh  = int'(r) + (to_wdog ? 0 : 1);
        return (one << sh) - one;
    endfunction
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    input  logic fall_sel,
    output logic pin_edge
);
    logic stg [SYNC_N];
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= pin_async;
    end

    for (genvar g = 1; g < SYNC_N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= 1'b0;
            else     stg[g] <= stg[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= stg[SYNC_N-1];
    end

    assign pin_edge = fall_sel ? (prev & ~stg[SYNC_N-1]) : (~prev & stg[SYNC_N-1]);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pin_edge |=> !pin_edge); // R5
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
    import tw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tmode_t mode,
    input  logic   mode_we,
    input  logic   cyc_tick,
    input  logic   pin_edge,
    input  logic   wd_tick,
    input  logic   cnt_we,
    input  logic   wd_restart,
    output logic   cnt_inc,
    output logic   wd_inc
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    logic             src_ev, pre_in, pre_hit, pre_clr;

    always_comb begin
        src_ev  = mode.src_pin ? pin_edge : cyc_tick;
        pre_in  = mode.to_wdog ? wd_tick : src_ev;
        mask    = ratio_mask(mode.ratio, mode.to_wdog);
        pre_hit = pre_in && ((pre_cnt & mask) == mask);
        pre_clr = mode_we || (mode.to_wdog ? wd_restart : cnt_we);
        cnt_inc = mode.to_wdog ? src_ev  : pre_hit;
        wd_inc  = mode.to_wdog ? pre_hit : wd_tick;
    end

    always_ff @(posedge clk) begin
        if (rst)          pre_cnt <= '0;
        else if (pre_clr) pre_cnt <= '0;
        else if (pre_in)  pre_cnt <= pre_cnt + 1'b1;
    end

    AST_INC_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc || wd_inc) |-> (cyc_tick || pin_edge || wd_tick)); // R4
    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (!mode.to_wdog && cnt_inc && !mode_we) |=> !(cnt_inc && !mode.to_wdog)); // R4
endmodule

// File: rtl/tw_rtc.sv
module tw_rtc #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (we)  cnt <= wdata;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> cnt == $past(wdata)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we && !inc) |=> $stable(cnt)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!we && inc && cnt == '1) |=> cnt == '0); // R3
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_inc,
    input  logic wd_clr,
    input  logic sleep_req,
    output logic wd_rst,
    output logic wake,
    output logic wd_tmo
);
    logic [WDT_W-1:0] wcnt;
    logic             asleep, restart, expire;

    assign restart = wd_clr | sleep_req;
    assign expire  = wd_inc && (wcnt == '1) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            asleep <= 1'b0;
            wd_rst <= 1'b0;
            wake   <= 1'b0;
            wd_tmo <= 1'b0;
        end else begin
            wd_rst <= expire;
            wake   <= expire & asleep;
            if (restart)     wcnt <= '0;
            else if (wd_inc) wcnt <= wcnt + 1'b1;
            if (sleep_req)   asleep <= 1'b1;
            else if (expire) asleep <= 1'b0;
            if (restart)     wd_tmo <= 1'b0;
            else if (expire) wd_tmo <= 1'b1;
        end
    end

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        wd_rst |=> !wd_rst); // R7
    AST_TMO_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        wd_rst |-> wd_tmo); // R7
    AST_RESTART_NO_RST: assert property (@(posedge clk) disable iff (rst)
        restart |=> !wd_rst); // R9
    AST_RESTART_TMO: assert property (@(posedge clk) disable iff (rst)
        restart |=> !wd_tmo); // R9
    AST_WAKE_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        wake |-> wd_rst); // R10
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top
    import tw_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WDT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_tick,
    input  logic              tpin,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              wd_clr,
    input  logic              sleep_req,
    input  logic              wd_tick,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              wd_rst,
    output logic              wake,
    output logic              wd_tmo
);
    tmode_t mode_q;
    logic   pin_edge, cnt_inc, wd_inc;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_RST;
        else if (mode_we) mode_q <= tmode_t'(mode_wdata);
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> mode_q == tmode_t'($past(mode_wdata))); // R2

    tw_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .pin_async(tpin),
        .fall_sel(mode_q.fall_edge), .pin_edge(pin_edge)
    );

    tw_prescaler u_pre (
        .clk(clk), .rst(rst), .mode(mode_q), .mode_we(mode_we),
        .cyc_tick(cyc_tick), .pin_edge(pin_edge), .wd_tick(wd_tick),
        .cnt_we(cnt_we), .wd_restart(wd_clr | sleep_req),
        .cnt_inc(cnt_inc), .wd_inc(wd_inc)
    );

    tw_rtc #(.CNT_W(CNT_W)) u_rtc (
        .clk(clk), .rst(rst), .inc(cnt_inc), .we(cnt_we),
        .wdata(cnt_wdata), .cnt(cnt_val)
    );

    tw_wdog #(.WDT_W(WDT_W)) u_wdog (
        .clk(clk), .rst(rst), .wd_inc(wd_inc), .wd_clr(wd_clr),
        .sleep_req(sleep_req), .wd_rst(wd_rst), .wake(wake), .wd_tmo(wd_tmo)
    );
endmodule

// File: tb/tb_tmr_wdog_top.sv
`timescale 1ns/1ps
module tb_tmr_wdog_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_tick, tpin, mode_we, cnt_we, wd_clr, sleep_req, wd_tick;
    logic [5:0] mode_wdata;
    logic [7:0] cnt_wdata;
    logic [7:0] cnt_val;
    logic       wd_rst, wake, wd_tmo;

    int n_checks = 0;
    int n_fail   = 0;
    int rst_seen = 0;
    int wake_seen = 0;

    always #5 clk = ~clk;

    tmr_wdog_top dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .tpin(tpin),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .wd_clr(wd_clr), .sleep_req(sleep_req),
        .wd_tick(wd_tick), .cnt_val(cnt_val), .wd_rst(wd_rst),
        .wake(wake), .wd_tmo(wd_tmo)
    );

    always @(negedge clk) begin
        if (wd_rst) rst_seen++;
        if (wake)   wake_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mode_wr(input logic [5:0] v);
        @(negedge clk) mode_we = 1'b1; mode_wdata = v;
        @(negedge clk) mode_we = 1'b0;
    endtask

    task automatic cnt_wr(input logic [7:0] v);
        @(negedge clk) cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk) cnt_we = 1'b0;
    endtask

    task automatic cyc_ticks(input int n);
        @(negedge clk) cyc_tick = 1'b1;
        repeat (n) @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic base_ticks(input int n);
        @(negedge clk) wd_tick = 1'b1;
        repeat (n) @(negedge clk);
        wd_tick = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk) wd_clr = 1'b1;
        @(negedge clk) wd_clr = 1'b0;
    endtask

    task automatic sleep_pulse();
        @(negedge clk) sleep_req = 1'b1;
        @(negedge clk) sleep_req = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk) tpin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 cnt", cnt_val, 0);
        chk("R1 wd_rst", wd_rst, 0);
        chk("R1 wake", wake, 0);
        chk("R1 wd_tmo", wd_tmo, 0);
        cyc_ticks(3);
        chk("R1 cyc_tick ignored under reset mode", cnt_val, 0);
    endtask

    task automatic t_internal();
        mode_wr(6'h08);
        cyc_ticks(5);
        chk("R3 count five ticks", cnt_val, 5);
        cnt_wr(8'hFE);
        chk("R6 load", cnt_val, 8'hFE);
        cyc_ticks(3);
        chk("R3 wrap", cnt_val, 8'h01);
        @(negedge clk) cnt_we = 1'b1; cnt_wdata = 8'h40; cyc_tick = 1'b1;
        @(negedge clk) cnt_we = 1'b0; cyc_tick = 1'b0;
        chk("R6 write beats increment", cnt_val, 8'h40);
    endtask

    task automatic t_prescale();
        mode_wr(6'h01);
        cnt_wr(8'h00);
        cyc_ticks(3);
        chk("R4 div4 before boundary", cnt_val, 0);
        cyc_ticks(1);
        chk("R4 div4 boundary", cnt_val, 1);
        cyc_ticks(4);
        chk("R4 div4 second", cnt_val, 2);
        mode_wr(6'h07);
        cnt_wr(8'h00);
        cyc_ticks(255);
        chk("R4 div256 before boundary", cnt_val, 0);
        cyc_ticks(1);
        chk("R4 div256 boundary", cnt_val, 1);
        mode_wr(6'h01);
        cnt_wr(8'h00);
        cyc_ticks(3);
        cnt_wr(8'h10);
        cyc_ticks(3);
        chk("R6 write clears prescaler", cnt_val, 8'h10);
        cyc_ticks(1);
        chk("R6 count after cleared prescaler", cnt_val, 8'h11);
    endtask

    task automatic t_mode_clear();
        cnt_wr(8'h00);
        cyc_ticks(2);
        mode_wr(6'h01);
        cyc_ticks(3);
        chk("R2 mode write clears prescaler", cnt_val, 0);
        cyc_ticks(1);
        chk("R2 count after mode write", cnt_val, 1);
    endtask

    task automatic t_pin();
        mode_wr(6'h28);
        cnt_wr(8'h00);
        set_pin(1'b1);
        chk("R5 rising counted", cnt_val, 1);
        set_pin(1'b0);
        chk("R5 falling ignored", cnt_val, 1);
        cyc_ticks(4);
        chk("R5 cyc_tick ignored", cnt_val, 1);
        mode_wr(6'h38);
        set_pin(1'b1);
        chk("R5 rising ignored", cnt_val, 1);
        set_pin(1'b0);
        chk("R5 falling counted", cnt_val, 2);
    endtask

    task automatic t_wdt_raw();
        int s;
        mode_wr(6'h00);
        clr_pulse();
        s = rst_seen;
        base_ticks(255);
        @(negedge clk);
        chk("R7 no reset before overflow", rst_seen, s);
        chk("R7 flag clear before overflow", wd_tmo, 0);
        base_ticks(1);
        chk("R7 reset pulse", wd_rst, 1);
        chk("R7 flag set", wd_tmo, 1);
        chk("R10 no wake when awake", wake, 0);
        @(negedge clk);
        chk("R7 pulse one cycle", wd_rst, 0);
    endtask

    task automatic t_restart();
        int s;
        clr_pulse();
        chk("R9 clear drops flag", wd_tmo, 0);
        base_ticks(200);
        clr_pulse();
        s = rst_seen;
        base_ticks(200);
        base_ticks(55);
        @(negedge clk);
        chk("R9 restart delays timeout", rst_seen, s);
        base_ticks(1);
        chk("R9 timeout after restart", wd_rst, 1);
        mode_wr(6'h09);
        clr_pulse();
        base_ticks(1);
        clr_pulse();
        s = rst_seen;
        base_ticks(511);
        @(negedge clk);
        chk("R8 R9 no reset before 512", rst_seen, s);
        base_ticks(1);
        chk("R8 timeout at 512 ticks", wd_rst, 1);
    endtask

    task automatic t_sleep();
        int s, w;
        mode_wr(6'h00);
        clr_pulse();
        base_ticks(100);
        sleep_pulse();
        chk("R9 sleep clears flag", wd_tmo, 0);
        s = rst_seen;
        w = wake_seen;
        base_ticks(255);
        @(negedge clk);
        chk("R9 sleep restarts count", rst_seen, s);
        chk("R10 no early wake", wake_seen, w);
        base_ticks(1);
        chk("R10 reset in sleep", wd_rst, 1);
        chk("R10 wake in sleep", wake, 1);
        @(negedge clk);
        chk("R10 wake one cycle", wake, 0);
        base_ticks(256);
        chk("R10 later timeout reset", wd_rst, 1);
        chk("R10 sleep ended", wake, 0);
    endtask

    initial begin
        rst = 1'b1;
        cyc_tick = 0; tpin = 0; mode_we = 0; cnt_we = 0;
        wd_clr = 0; sleep_req = 0; wd_tick = 0;
        mode_wdata = '0; cnt_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_internal();
        t_prescale();
        t_mode_clear();
        t_pin();
        t_wdt_raw();
        t_restart();
        t_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule